// File: doc/BRIEF.md
# Single-Shot Converter Sequencer

This block runs one analog-to-digital conversion at a time for a polled, low-power use. Software sets a channel number, a result width and an invert option through a small register port. It then starts a measurement by writing the start bit as 0 and then as 1. The sequencer accepts the start only when nothing is in flight. It drives a one-hot pad enable and a start request to the converter and waits for the converter's busy/done handshake. When the converter finishes, the sequencer stores the formatted result and raises a done flag. Software polls the flag and reads the result.

A programmable divider makes a clock-enable pulse for the converter's slower clock. A start edge that arrives while a measurement is running has no effect on that measurement. Instead it sets a sticky overrun flag, which software clears by writing 1 to it.

Register map (2-bit address): 0 = control (bit 0 start, bit 1 invert, bits 3:2 width code, bits 7:4 channel), 1 = divider (bits 7:0), 2 = status (bit 0 idle, bit 1 done, bit 2 overrun; writing 1 to bit 2 clears overrun), 3 = result (read only).

Top module: `sconv_ctrl`

## Requirements
- R1: While a measurement is in flight, `cnv_chan_en` has exactly bit N set, where N is the channel captured at the start. Otherwise it is all zero.
- R2: A measurement starts only on a write to address 0 with bit 0 = 1 when the previously written start bit was 0. Writing 1 again while the stored bit is already 1 starts nothing.
- R3: A start is accepted only while `stat_idle` is high, meaning the sequencer is idle and `cnv_busy` is low. `stat_idle` goes low in the cycle after acceptance.
- R4: A start edge that arrives while not idle leaves the running measurement unchanged, including its channel and width. It sets `stat_overrun`, which stays set until a write to address 2 with bit 2 = 1.
- R5: An accepted start clears `stat_done`. A `cnv_done` pulse during a measurement latches the result into `res_value` and sets `stat_done` on the next edge.
- R6: Width codes 0, 1, 2 and 3 keep the low 9, 10, 11 or 12 bits of `cnv_data`. All higher result bits are zero.
- R7: With the invert bit set, the kept bits are complemented and the higher bits stay zero.
- R8: `cnv_clk_en` pulses once every D+1 cycles, where D is the divider value. Writing the divider restarts the count. After reset D = 0, so it pulses every cycle.
- R9: `reg_rdata` returns the control fields at address 0, the divider at 1, status {overrun, done, idle} in bits 2:0 at 2, and the result at 3.
- R10: After reset, idle = 1, done = 0, overrun = 0, the result is 0, `cnv_start` is 0 and no channel is enabled.
- R11: `cnv_start` is held from acceptance until `cnv_busy` is seen high, then drops. The width code sent on `cnv_width` is the one captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on address) |
| cnv_clk_en | output | 1 | Divided converter clock enable |
| cnv_start | output | 1 | Conversion request to converter |
| cnv_chan_en | output | 16 | One-hot pad enable |
| cnv_width | output | 2 | Width code for converter |
| cnv_busy | input | 1 | Converter busy |
| cnv_done | input | 1 | Converter done pulse |
| cnv_data | input | 12 | Converter raw data |
| stat_idle | output | 1 | Ready to accept a start |
| stat_done | output | 1 | Result available |
| stat_overrun | output | 1 | Sticky ignored-start flag |
| res_value | output | 12 | Latched formatted result |

## Verification
On every cycle, the assertions check several properties. The pad enable stays one-hot while a request is raised. A new request appears only after an idle cycle, and the request is held until the converter reports busy. Overrun stays sticky unless cleared, and acceptance clears done. A done result never has bits above its width. The divider never pulses twice in a row when D > 0, and no two start edges occur back to back. Only the bench scenarios can show the rest: the actual result values for each width and invert mix, the exact pulse count of the divider, the register readback, and that an ignored start keeps the earlier channel and width.

// File: rtl/sconv_pkg.sv
// Shared definitions for the single-shot converter sequencer.
// Assumes a 2-bit register address space and field positions fixed here.
package sconv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_RES  = 2'd3;

    localparam int F_START = 0;
    localparam int F_INV   = 1;
    localparam int F_WID   = 2;
    localparam int F_CHAN  = 4;

    localparam int S_IDLE  = 0;
    localparam int S_DONE  = 1;
    localparam int S_OVR   = 2;

endpackage

// File: rtl/sconv_regs.sv
// Register port: holds the control fields, divider and start bit, detects the
// 0-to-1 start edge and multiplexes read data. Assumes RW covers all fields.
module sconv_regs
    import sconv_pkg::*;
#(
    parameter int RW   = 16,
    parameter int CHW  = 4,
    parameter int DIVW = 8,
    parameter int DW   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [RW-1:0]   wdata,
    output logic [RW-1:0]   rdata,
    input  logic            stat_idle,
    input  logic            stat_done,
    input  logic            stat_ovr,
    input  logic [DW-1:0]   res_value,
    output logic            cfg_inv,
    output logic [1:0]      cfg_wid,
    output logic [CHW-1:0]  cfg_chan,
    output logic [DIVW-1:0] cfg_div,
    output logic            div_load,
    output logic            start_edge,
    output logic            ovr_clear
);

    localparam int HI_USED = ((F_CHAN + CHW) > DIVW) ? (F_CHAN + CHW) : DIVW;

    logic start_q;
    logic ctrl_wr;

    assign ctrl_wr    = wr_en && (addr == A_CTRL);
    assign start_edge = ctrl_wr && wdata[F_START] && !start_q;
    assign div_load   = wr_en && (addr == A_DIV);
    assign ovr_clear  = wr_en && (addr == A_STAT) && wdata[S_OVR];

    // Store control fields and the last written start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            cfg_inv  <= 1'b0;
            cfg_wid  <= 2'd0;
            cfg_chan <= '0;
        end else if (ctrl_wr) begin
            start_q  <= wdata[F_START];
            cfg_inv  <= wdata[F_INV];
            cfg_wid  <= wdata[F_WID +: 2];
            cfg_chan <= wdata[F_CHAN +: CHW];
        end
    end

    // Store the divider value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_div <= '0;
        end else if (div_load) begin
            cfg_div <= wdata[DIVW-1:0];
        end
    end

    // Select read data by address.
    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = RW'({cfg_chan, cfg_wid, cfg_inv, start_q});
            A_DIV:   rdata = RW'(cfg_div);
            A_STAT:  rdata = RW'({stat_ovr, stat_done, stat_idle});
            default: rdata = RW'(res_value);
        endcase
    end

    generate
        if (RW > HI_USED) begin : g_spare
            logic unused_wbits;
            assign unused_wbits = ^wdata[RW-1:HI_USED];
        end
    endgenerate

    // R2
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_edge |=> !start_edge);

endmodule

// File: rtl/sconv_clkdiv.sv
// Converter clock enable: one pulse every div+1 fast-clock cycles.
// Assumes a write of the divider restarts the count from zero.
module sconv_clkdiv #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div,
    input  logic            load,
    output logic            tick
);

    logic [DIVW-1:0] cnt_q;

    assign tick = (cnt_q == div);

    // Count up to the divider value and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && (div != '0)) |=> (!tick || (div == '0)));

endmodule

// File: rtl/sconv_fmt.sv
// Result formatter: keeps the low DW-3+wid bits, optionally complemented,
// and zeroes the rest. Assumes DW >= 4 so the four widths fit.
module sconv_fmt #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] raw,
    input  logic [1:0]    wid,
    input  logic          inv,
    output logic [DW-1:0] val
);

    localparam int MINW = DW - 3;

    logic [DW-1:0] mask;

    generate
        for (genvar i = 0; i < DW; i++) begin : g_mask
            assign mask[i] = (32'(i) < (32'(MINW) + 32'(wid)));
        end
    endgenerate

    assign val = (inv ? ~raw : raw) & mask;

endmodule

// File: rtl/sconv_seq.sv
// Measurement sequencer: accepts a start edge only when idle, captures the
// settings, handshakes with the converter and latches the formatted result.
// Assumes the converter raises busy after seeing start and pulses done once.
module sconv_seq
    import sconv_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CHW = 4,
    parameter int DW  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_edge,
    input  logic            ovr_clear,
    input  logic            cfg_inv,
    input  logic [1:0]      cfg_wid,
    input  logic [CHW-1:0]  cfg_chan,
    input  logic            cnv_busy,
    input  logic            cnv_done,
    input  logic [DW-1:0]   cnv_data,
    output logic            cnv_start,
    output logic [NCH-1:0]  cnv_chan_en,
    output logic [1:0]      cnv_width,
    output logic            stat_idle,
    output logic            stat_done,
    output logic            stat_ovr,
    output logic [DW-1:0]   res_value
);

    seq_state_e     state_q;
    logic [CHW-1:0] chan_q;
    logic [1:0]     wid_q;
    logic           inv_q;
    logic           accept;
    logic           finish;
    logic           active;
    logic [DW-1:0]  fmt_val;

    assign stat_idle = (state_q == ST_IDLE) && !cnv_busy;
    assign accept    = start_edge && stat_idle;
    assign finish    = (state_q == ST_WAIT) && cnv_done;
    assign active    = (state_q != ST_IDLE);
    assign cnv_start = (state_q == ST_REQ);
    assign cnv_width = wid_q;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_pad
            assign cnv_chan_en[i] = active && (chan_q == CHW'(i));
        end
    endgenerate

    sconv_fmt #(.DW(DW)) u_fmt (
        .raw (cnv_data),
        .wid (wid_q),
        .inv (inv_q),
        .val (fmt_val)
    );

    // Step the request/wait/idle sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept)   state_q <= ST_REQ;
                ST_REQ:  if (cnv_busy) state_q <= ST_WAIT;
                ST_WAIT: if (cnv_done) state_q <= ST_IDLE;
                default:               state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the measurement settings at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            wid_q  <= 2'd0;
            inv_q  <= 1'b0;
        end else if (accept) begin
            chan_q <= cfg_chan;
            wid_q  <= cfg_wid;
            inv_q  <= cfg_inv;
        end
    end

    // Maintain the done flag and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_done <= 1'b0;
            res_value <= '0;
        end else if (accept) begin
            stat_done <= 1'b0;
        end else if (finish) begin
            stat_done <= 1'b1;
            res_value <= fmt_val;
        end
    end

    // Set overrun on an ignored start edge; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_ovr <= 1'b0;
        end else if (start_edge && !accept) begin
            stat_ovr <= 1'b1;
        end else if (ovr_clear) begin
            stat_ovr <= 1'b0;
        end
    end

    // R1
    pad_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> ($countones(cnv_chan_en) == 1));

    // R3
    idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_start) |-> $past(stat_idle));

    // R4
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ovr && !ovr_clear) |=> stat_ovr);

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_edge && stat_idle) |=> (!stat_done && !stat_idle));

    // R6
    res_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> ((32'(res_value) >> (32'(DW - 3) + 32'(wid_q))) == 0));

    // R11
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_start && !cnv_busy) |=> cnv_start);

endmodule

// File: rtl/sconv_ctrl.sv
// Top of the single-shot converter sequencer: register port, clock divider
// and measurement sequencer. Assumes RW is wide enough for every field.
module sconv_ctrl
    import sconv_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int DW   = 12,
    parameter int DIVW = 8,
    parameter int RW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_en,
    input  logic [1:0]      reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    output logic            cnv_clk_en,
    output logic            cnv_start,
    output logic [NCH-1:0]  cnv_chan_en,
    output logic [1:0]      cnv_width,
    input  logic            cnv_busy,
    input  logic            cnv_done,
    input  logic [DW-1:0]   cnv_data,
    output logic            stat_idle,
    output logic            stat_done,
    output logic            stat_overrun,
    output logic [DW-1:0]   res_value
);

    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic            cfg_inv;
    logic [1:0]      cfg_wid;
    logic [CHW-1:0]  cfg_chan;
    logic [DIVW-1:0] cfg_div;
    logic            div_load;
    logic            start_edge;
    logic            ovr_clear;

    sconv_regs #(.RW(RW), .CHW(CHW), .DIVW(DIVW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .stat_idle  (stat_idle),
        .stat_done  (stat_done),
        .stat_ovr   (stat_overrun),
        .res_value  (res_value),
        .cfg_inv    (cfg_inv),
        .cfg_wid    (cfg_wid),
        .cfg_chan   (cfg_chan),
        .cfg_div    (cfg_div),
        .div_load   (div_load),
        .start_edge (start_edge),
        .ovr_clear  (ovr_clear)
    );

    sconv_clkdiv #(.DIVW(DIVW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (cfg_div),
        .load  (div_load),
        .tick  (cnv_clk_en)
    );

    sconv_seq #(.NCH(NCH), .CHW(CHW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_edge  (start_edge),
        .ovr_clear   (ovr_clear),
        .cfg_inv     (cfg_inv),
        .cfg_wid     (cfg_wid),
        .cfg_chan    (cfg_chan),
        .cnv_busy    (cnv_busy),
        .cnv_done    (cnv_done),
        .cnv_data    (cnv_data),
        .cnv_start   (cnv_start),
        .cnv_chan_en (cnv_chan_en),
        .cnv_width   (cnv_width),
        .stat_idle   (stat_idle),
        .stat_done   (stat_done),
        .stat_ovr    (stat_overrun),
        .res_value   (res_value)
    );

endmodule

// File: tb/sconv_ctrl_tb.sv
// Scoreboard bench: a driver pushes expected results, a monitor pops them
// when done rises. A behavioural converter answers the handshake.
module sconv_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cnv_clk_en;
    logic        cnv_start;
    logic [15:0] cnv_chan_en;
    logic [1:0]  cnv_width;
    logic        cnv_busy = 1'b0;
    logic        cnv_done = 1'b0;
    logic [11:0] cnv_data = '0;
    logic        stat_idle;
    logic        stat_done;
    logic        stat_overrun;
    logic [11:0] res_value;

    int checks = 0;
    int errors = 0;
    int lat = 3;
    int mcnt = 0;
    logic [11:0] model_data = '0;
    logic [11:0] exp_q[$];
    logic prev_done = 1'b0;

    always #10 clk = ~clk;

    sconv_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnv_clk_en(cnv_clk_en),
        .cnv_start(cnv_start), .cnv_chan_en(cnv_chan_en), .cnv_width(cnv_width),
        .cnv_busy(cnv_busy), .cnv_done(cnv_done), .cnv_data(cnv_data),
        .stat_idle(stat_idle), .stat_done(stat_done), .stat_overrun(stat_overrun),
        .res_value(res_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] expect_val(input logic [11:0] d,
                                               input int code, input bit inv);
        logic [11:0] m;
        m = 12'((32'd1 << (9 + code)) - 1);
        return inv ? (~d & m) : (d & m);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [15:0] ctrl_word(input int ch, input int code,
                                              input bit inv, input bit st);
        return 16'((ch << 4) | (code << 2) | (int'(inv) << 1) | int'(st));
    endfunction

    // Driver: queue the expected result, then write start 0 then 1.
    task automatic start_conv(input int ch, input int code, input bit inv,
                              input logic [11:0] d);
        model_data = d;
        exp_q.push_back(expect_val(d, code, inv));
        wr(2'd0, ctrl_word(ch, code, inv, 1'b0));
        wr(2'd0, ctrl_word(ch, code, inv, 1'b1));
    endtask

    task automatic wait_done();
        for (int i = 0; i < 100; i++) begin
            if (stat_done) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    // Behavioural converter: busy after start, done pulse after lat cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            cnv_busy = 1'b0; cnv_done = 1'b0;
        end else if (cnv_done) begin
            cnv_done = 1'b0; cnv_busy = 1'b0;
        end else if (cnv_busy) begin
            if (mcnt == 0) begin
                cnv_done = 1'b1; cnv_data = model_data;
            end else begin
                mcnt--;
            end
        end else if (cnv_start) begin
            cnv_busy = 1'b1; mcnt = lat;
        end
    end

    // Monitor: compare the result against the queue when done rises.
    always @(negedge clk) begin
        if (rst_n && stat_done && !prev_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected done", 32'(res_value), 32'hFFFF);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                chk(res_value == e, "R5 R6 R7 result", 32'(res_value), 32'(e));
            end
        end
        prev_done = stat_done;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        int ticks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(stat_idle && !stat_done && !stat_overrun, "R10 status", {stat_overrun, stat_done, stat_idle}, 32'h1);
        chk(res_value == 0 && !cnv_start && cnv_chan_en == 0, "R10 outputs", 32'(cnv_chan_en), 32'h0);
        rd(2'd2, rv);
        chk(rv == 16'h1, "R9 status read", rv, 32'h1);

        // R8 divider at reset value 0
        ticks = 0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); if (cnv_clk_en) ticks++; end
        chk(ticks == 5, "R8 div0", ticks, 5);

        // R1 R3 R11 first conversion
        start_conv(5, 3, 1'b0, 12'hABC);
        chk(cnv_chan_en == 16'h0020, "R1 one-hot ch5", cnv_chan_en, 16'h0020);
        chk(cnv_start && cnv_width == 2'd3, "R11 request", {cnv_width, cnv_start}, 32'h7);
        chk(!stat_idle, "R3 not idle", stat_idle, 0);
        wait_done();
        chk(cnv_chan_en == 0 && !cnv_start, "R1 released", cnv_chan_en, 0);
        rd(2'd3, rv);
        chk(rv == 16'h0ABC, "R9 result read", rv, 16'h0ABC);

        // R2 rewriting 1 over a stored 1 starts nothing
        wr(2'd0, ctrl_word(5, 3, 1'b0, 1'b1));
        chk(!cnv_start && stat_idle && stat_done, "R2 no restart", {stat_done, stat_idle, cnv_start}, 32'h6);

        // R6 R7 widths and inversion, channel boundaries
        start_conv(0, 0, 1'b0, 12'hFFF);
        chk(cnv_chan_en == 16'h0001, "R1 ch0", cnv_chan_en, 16'h0001);
        chk(!stat_done, "R5 done cleared", stat_done, 0);
        wait_done();
        start_conv(15, 1, 1'b1, 12'h0F0);
        chk(cnv_chan_en == 16'h8000, "R1 ch15", cnv_chan_en, 16'h8000);
        wait_done();
        start_conv(9, 2, 1'b1, 12'h7FF);
        wait_done();
        start_conv(2, 3, 1'b1, 12'h000);
        wait_done();

        // R4 overrun: a start while busy is ignored and sticky
        lat = 8;
        start_conv(3, 2, 1'b0, 12'h555);
        wr(2'd0, ctrl_word(7, 0, 1'b1, 1'b0));
        wr(2'd0, ctrl_word(7, 0, 1'b1, 1'b1));
        chk(stat_overrun, "R4 overrun set", stat_overrun, 1);
        chk(cnv_chan_en == 16'h0008 && cnv_width == 2'd2, "R4 settings kept", cnv_chan_en, 16'h0008);
        wait_done();
        chk(stat_overrun, "R4 sticky", stat_overrun, 1);
        wr(2'd2, 16'h0004);
        chk(!stat_overrun, "R4 cleared", stat_overrun, 0);
        lat = 3;

        // R9 control readback
        wr(2'd0, ctrl_word(7, 1, 1'b0, 1'b0));
        rd(2'd0, rv);
        chk(rv == 16'h0074, "R9 ctrl read", rv, 16'h0074);

        // R8 divider of 3 gives one pulse every 4 cycles
        wr(2'd1, 16'h0003);
        rd(2'd1, rv);
        chk(rv == 16'h0003, "R9 div read", rv, 3);
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            if (cnv_clk_en) ticks++;
            @(negedge clk);
        end
        chk(ticks == 10, "R8 div3", ticks, 10);

        chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule